// File: doc/BRIEF.md
# Bit-Serial Register Slave with Board Reset Request

This block is the slave end of a four-wire bit-serial register link: a clock, a data line into the block, a data line out of the block, and an active-low strobe. The block oversamples all three incoming lines with its own system clock. It finds the serial clock edges in that domain and shifts the incoming bits into a history register. When it sees a serial clock rising edge while the strobe is low, it treats that edge as a command. The data-in value on that edge chooses between a read and a write.

A write frame carries a 32-bit word followed by an 8-bit address, so the address is the last thing shifted in before the command. A read frame carries only the 8-bit address. After the command clock, the master gives 32 more clocks, and the block shifts the selected register out MSB first. The register file holds these registers:
- two writable configuration words, each driven onto output pins;
- a read-only view of a 32-bit switch input;
- a reset-control register;
- a read-only version constant.

Setting bit 0 of the reset-control register raises a board reset request for a fixed number of system clocks. The bit then clears itself.

Top module: `bsr_slave`

## Requirements
- R1: After reset, `ser_dout_o` is 1, `rst_req_o` is 0, and `mode_o` and `mux_o` are all zeros.
- R2: A write to address 0x00 loads the 32-bit word into the mode register. `mode_o` then shows that word, and a read of 0x00 returns it.
- R3: A write to address 0x02 loads the multiplexer register. `mux_o` then shows that word, and a read of 0x02 returns it.
- R4: A read of address 0x08 returns the current value of `sw_i`. A write to 0x08 changes neither `mode_o` nor `mux_o`, and a later read still returns `sw_i`.
- R5: A read of address 0xFF returns the parameter `VERSION`. A write to 0xFF has no effect.
- R6: A read of any other address returns zero. A write to any other address changes no register.
- R7: A write to 0x80 with bit 0 set holds `rst_req_o` high for exactly `RST_CYCLES` system clocks. The bit then clears, so a later read of 0x80 returns zero. A write to 0x80 with bit 0 clear raises no request.
- R8: Read data leaves the block MSB first. Bit 31 appears only after the command clock falls, and each later serial clock falling edge moves to the next bit. `ser_dout_o` is 1 while the command clock is still high and whenever no read is in progress.
- R9: A write commits only the last 40 bits shifted before the command, taking data from the upper 32 bits and the address from the lower 8. Extra leading bits are discarded.
- R10: A command is a serial clock rising edge with the strobe low. Data-in equal to 0 on that edge means read, and 1 means write. Rising edges with the strobe high only shift data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock from the master, asynchronous |
| ser_din_i | input | 1 | Serial data from the master, asynchronous |
| strobe_n_i | input | 1 | Active-low command strobe, idles high |
| sw_i | input | 32 | Switch inputs, returned at address 0x08 |
| ser_dout_o | output | 1 | Serial read data to the master, high when idle |
| mode_o | output | 32 | Mode register contents |
| mux_o | output | 32 | Multiplexer register contents |
| rst_req_o | output | 1 | Board reset request pulse |

## Verification
Random writes and reads draw their addresses from both the mapped set and arbitrary bytes, and their data from random words. This separates correct address decoding from aliasing or partial decoding. Directed patterns are used for these cases:
- alternating and single-bit data words, which expose bit-order or off-by-one shift errors;
- a write frame preceded by extra junk bits, which tells whether the commit uses the last 40 bits;
- reset-control writes with bit 0 set and with bit 0 clear, whose measured pulse lengths distinguish a correct counter from an early or late release;
- an idle-line sample taken while the command clock is high, which shows whether the first read bit waits for the falling edge.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned FRAME_W = WORD_W + ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_MODE    = 8'h00;
    localparam addr_t A_MUX     = 8'h02;
    localparam addr_t A_SWITCH  = 8'h08;
    localparam addr_t A_RESET   = 8'h80;
    localparam addr_t A_VERSION = 8'hFF;

    // One synchronised serial line with its edges in the system domain
    typedef struct packed {
        logic lvl;
        logic rise;
        logic fall;
    } line_t;

    // Decoded command, valid for one system clock
    typedef struct packed {
        logic  wr;
        logic  rd;
        addr_t addr;
        word_t data;
    } cmd_t;

    typedef enum logic [1:0] {TX_IDLE, TX_ARMED, TX_SHIFT} tx_state_e;

    function automatic addr_t frame_addr(input logic [FRAME_W-1:0] f);
        return f[ADDR_W-1:0];
    endfunction

    function automatic word_t frame_data(input logic [FRAME_W-1:0] f);
        return f[FRAME_W-1:ADDR_W];
    endfunction
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync
    import bsr_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d_i,
    output line_t q_o
);
    // STAGES flops of synchroniser plus one history flop for edge detection
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {(STAGES+1){IDLE}};
        else     chain <= {chain[STAGES-1:0], d_i};
    end

    always_comb begin
        q_o.lvl  = chain[STAGES-1];
        q_o.rise = chain[STAGES-1] & ~chain[STAGES];
        q_o.fall = ~chain[STAGES-1] & chain[STAGES];
    end
endmodule

// File: rtl/bsr_rx.sv
module bsr_rx
    import bsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  line_t sck_i,
    input  line_t din_i,
    input  line_t stb_i,
    output cmd_t  cmd_o
);
    logic [FRAME_W-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            cmd_o <= '0;
        end else begin
            cmd_o.wr <= 1'b0;
            cmd_o.rd <= 1'b0;
            if (sck_i.rise) begin
                if (stb_i.lvl) begin
                    hist <= {hist[FRAME_W-2:0], din_i.lvl};
                end else begin
                    cmd_o.wr   <= din_i.lvl;
                    cmd_o.rd   <= ~din_i.lvl;
                    cmd_o.addr <= frame_addr(hist);
                    cmd_o.data <= frame_data(hist);
                end
            end
        end
    end

    // R10: a command only follows a clock rise seen with the strobe low
    a_r10_cmd_source: assert property (@(posedge clk) disable iff (rst)
        (cmd_o.wr || cmd_o.rd) |-> $past(sck_i.rise && !stb_i.lvl));

    // R10: the strobe only moves while the serial clock is low
    a_r10_strobe_on_low: assert property (@(posedge clk) disable iff (rst)
        (stb_i.rise || stb_i.fall) |-> !sck_i.lvl);

    // R9: data-in is settled before the sampling edge
    a_r9_din_setup: assert property (@(posedge clk) disable iff (rst)
        (din_i.rise || din_i.fall) |-> !sck_i.rise);
endmodule

// File: rtl/bsr_regs.sv
module bsr_regs
    import bsr_pkg::*;
#(
    parameter word_t       VERSION    = 32'h0000_0001,
    parameter int unsigned RST_CYCLES = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  cmd_t  cmd_i,
    input  word_t sw_i,
    output word_t rdata_o,
    output word_t mode_o,
    output word_t mux_o,
    output logic  rst_req_o
);
    localparam int unsigned CNT_W = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RST_CYCLES - 1);

    word_t            mode_q, mux_q;
    logic             rst_bit;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            mux_q   <= '0;
            rst_bit <= 1'b0;
            cnt     <= '0;
        end else if (cmd_i.wr) begin
            case (cmd_i.addr)
                A_MODE:  mode_q <= cmd_i.data;
                A_MUX:   mux_q  <= cmd_i.data;
                A_RESET: begin
                    rst_bit <= cmd_i.data[0];
                    cnt     <= '0;
                end
                default: ;
            endcase
        end else if (rst_bit) begin
            if (cnt == CNT_LAST) begin
                rst_bit <= 1'b0;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (cmd_i.addr)
            A_MODE:    rdata_o = mode_q;
            A_MUX:     rdata_o = mux_q;
            A_SWITCH:  rdata_o = sw_i;
            A_RESET:   rdata_o = {{(WORD_W-1){1'b0}}, rst_bit};
            A_VERSION: rdata_o = VERSION;
            default:   rdata_o = '0;
        endcase
    end

    assign mode_o    = mode_q;
    assign mux_o     = mux_q;
    assign rst_req_o = rst_bit;

    // R7: a request only starts from a reset-register write with bit 0 set
    a_r7_req_source: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> $past(cmd_i.wr && cmd_i.addr == A_RESET && cmd_i.data[0]));

    // R7: pulse counter never passes its limit
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        rst_bit |-> (cnt <= CNT_LAST));

    // R4/R5/R6: writes elsewhere leave the mode word alone
    a_r4_mode_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && cmd_i.addr != A_MODE) |=> $stable(mode_o));

    // R6: writes elsewhere leave the multiplexer word alone
    a_r6_mux_kept: assert property (@(posedge clk) disable iff (rst)
        (cmd_i.wr && cmd_i.addr != A_MUX) |=> $stable(mux_o));
endmodule

// File: rtl/bsr_tx.sv
module bsr_tx
    import bsr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load_i,
    input  word_t word_i,
    input  line_t sck_i,
    output logic  dout_o
);
    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);

    tx_state_e        state;
    word_t            sh;
    logic [IDX_W-1:0] idx;
    logic             dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            sh     <= '0;
            idx    <= '0;
            dout_q <= 1'b1;
        end else if (load_i) begin
            sh     <= word_i;
            state  <= TX_ARMED;
            dout_q <= 1'b1;
        end else if (sck_i.fall) begin
            case (state)
                TX_ARMED: begin
                    dout_q <= sh[WORD_W-1];
                    sh     <= sh << 1;
                    idx    <= '0;
                    state  <= TX_SHIFT;
                end
                TX_SHIFT: begin
                    if (idx == IDX_LAST) begin
                        dout_q <= 1'b1;
                        state  <= TX_IDLE;
                    end else begin
                        dout_q <= sh[WORD_W-1];
                        sh     <= sh << 1;
                        idx    <= idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign dout_o = dout_q;

    // R8: output only changes on a falling edge or a new load
    a_r8_hold_between_falls: assert property (@(posedge clk) disable iff (rst)
        (!sck_i.fall && !load_i) |=> $stable(dout_o));

    // R8: the line rests high while no bit is being presented
    a_r8_idle_high: assert property (@(posedge clk) disable iff (rst)
        (state != TX_SHIFT) |-> dout_o);
endmodule

// File: rtl/bsr_slave.sv
module bsr_slave
    import bsr_pkg::*;
#(
    parameter word_t       VERSION     = 32'h0000_0001,
    parameter int unsigned RST_CYCLES  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ser_clk_i,
    input  logic        ser_din_i,
    input  logic        strobe_n_i,
    input  logic [31:0] sw_i,
    output logic        ser_dout_o,
    output logic [31:0] mode_o,
    output logic [31:0] mux_o,
    output logic        rst_req_o
);
    localparam int unsigned N_LINES = 3;
    localparam logic [N_LINES-1:0] LINE_IDLE = 3'b100; // strobe idles high

    logic [N_LINES-1:0] raw;
    line_t              lines [N_LINES];
    cmd_t               cmd;
    word_t              rdata;

    assign raw = {strobe_n_i, ser_din_i, ser_clk_i};

    for (genvar i = 0; i < N_LINES; i++) begin : g_sync
        bsr_sync #(.STAGES(SYNC_STAGES), .IDLE(LINE_IDLE[i])) u_sync (
            .clk (clk),
            .rst (rst),
            .d_i (raw[i]),
            .q_o (lines[i])
        );
    end

    bsr_rx u_rx (
        .clk   (clk),
        .rst   (rst),
        .sck_i (lines[0]),
        .din_i (lines[1]),
        .stb_i (lines[2]),
        .cmd_o (cmd)
    );

    bsr_regs #(.VERSION(VERSION), .RST_CYCLES(RST_CYCLES)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .sw_i      (sw_i),
        .rdata_o   (rdata),
        .mode_o    (mode_o),
        .mux_o     (mux_o),
        .rst_req_o (rst_req_o)
    );

    bsr_tx u_tx (
        .clk    (clk),
        .rst    (rst),
        .load_i (cmd.rd),
        .word_i (rdata),
        .sck_i  (lines[0]),
        .dout_o (ser_dout_o)
    );
endmodule

// File: tb/bsr_slave_tb.sv
module bsr_slave_tb_top;
    localparam logic [31:0] VER  = 32'hA5C3_0102;
    localparam int          RSTN = 16;
    localparam int          HP   = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sck = 1'b0;
    logic        din = 1'b0;
    logic        stb_n = 1'b1;
    logic [31:0] sw = 32'h0;
    logic        dout;
    logic [31:0] mode_w, mux_w;
    logic        rreq;

    int checks = 0;
    int errors = 0;
    int rst_hi = 0;
    logic cmd_high_dout;
    logic [31:0] mode_m = 0, mux_m = 0;

    always #5 clk = ~clk;

    bsr_slave #(.VERSION(VER), .RST_CYCLES(RSTN)) dut_i (
        .clk(clk), .rst(rst), .ser_clk_i(sck), .ser_din_i(din),
        .strobe_n_i(stb_n), .sw_i(sw), .ser_dout_o(dout),
        .mode_o(mode_w), .mux_o(mux_w), .rst_req_o(rreq)
    );

    always @(negedge clk) if (rreq) rst_hi++;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        din = b;
        wait_n(HP);
        sck = 1'b1;
        smp = dout;
        wait_n(HP);
        sck = 1'b0;
    endtask

    task automatic command(input logic wr);
        din = wr;
        wait_n(HP);
        stb_n = 1'b0;
        wait_n(HP);
        sck = 1'b1;
        wait_n(HP);
        cmd_high_dout = dout;
        sck = 1'b0;
        wait_n(HP);
        stb_n = 1'b1;
    endtask

    task automatic ser_read(input logic [7:0] a, output logic [31:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(a[i], s);
        command(1'b0);
        for (int i = 31; i >= 0; i--) begin
            clk_bit(1'b0, s);
            d[i] = s;
        end
        wait_n(HP);
    endtask

    task automatic ser_write(input logic [7:0] a, input logic [31:0] d);
        logic s;
        for (int i = 31; i >= 0; i--) clk_bit(d[i], s);
        for (int i = 7; i >= 0; i--) clk_bit(a[i], s);
        command(1'b1);
        wait_n(HP);
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00: return mode_m;
            8'h02: return mux_m;
            8'h08: return sw;
            8'hFF: return VER;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h02: return "R3";
            8'h08: return "R4";
            8'hFF: return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  a;
        logic [31:0] d;
        logic        s;
        void'($urandom(32'd1234));
        sw = 32'h1357_9BDF;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);

        // R1 reset state
        chk("R1 dout", {31'b0, dout}, 32'h1);
        chk("R1 rst_req", {31'b0, rreq}, 32'h0);
        chk("R1 mode", mode_w, 32'h0);
        chk("R1 mux", mux_w, 32'h0);

        // R2, R3 directed
        ser_write(8'h00, 32'hAAAA_5555); mode_m = 32'hAAAA_5555;
        chk("R2 mode_o", mode_w, mode_m);
        ser_read(8'h00, rd); chk("R2 readback", rd, mode_m);
        chk("R8 idle after read", {31'b0, dout}, 32'h1);
        chk("R8 no bit before command fall", {31'b0, cmd_high_dout}, 32'h1);
        ser_write(8'h02, 32'h8000_0001); mux_m = 32'h8000_0001;
        chk("R3 mux_o", mux_w, mux_m);
        ser_read(8'h02, rd); chk("R3 readback R8 order", rd, mux_m);

        // R4 switch read and ignored write
        ser_read(8'h08, rd); chk("R4 switch", rd, sw);
        ser_write(8'h08, 32'hFFFF_FFFF);
        chk("R4 mode unchanged", mode_w, mode_m);
        chk("R4 mux unchanged", mux_w, mux_m);
        ser_read(8'h08, rd); chk("R4 switch after write", rd, sw);

        // R5 version
        ser_write(8'hFF, 32'h0);
        ser_read(8'hFF, rd); chk("R5 version", rd, VER);

        // R6 unmapped
        ser_write(8'h41, 32'hDEAD_BEEF);
        ser_read(8'h41, rd); chk("R6 unmapped read", rd, 32'h0);
        chk("R6 mode unchanged", mode_w, mode_m);
        chk("R6 mux unchanged", mux_w, mux_m);

        // R9 leading junk bits discarded
        for (int i = 0; i < 8; i++) clk_bit(1'b1, s);
        ser_write(8'h00, 32'h0F0F_00F0); mode_m = 32'h0F0F_00F0;
        chk("R9 mode after junk", mode_w, mode_m);
        chk("R9 mux untouched", mux_w, mux_m);

        // R7 reset pulse
        rst_hi = 0;
        ser_write(8'h80, 32'h0000_0000);
        wait_n(40);
        chk("R7 zero write no pulse", rst_hi, 0);
        rst_hi = 0;
        ser_write(8'h80, 32'h0000_0001);
        wait_n(40);
        chk("R7 pulse length", rst_hi, RSTN);
        chk("R7 req released", {31'b0, rreq}, 32'h0);
        ser_read(8'h80, rd); chk("R7 bit cleared", rd, 32'h0);

        // R10 a read command must not write: mode kept across reads
        ser_read(8'h00, rd); chk("R10 read leaves mode", mode_w, mode_m);

        // random mix
        for (int n = 0; n < 30; n++) begin
            case ($urandom_range(0, 5))
                0: a = 8'h00;
                1: a = 8'h02;
                2: a = 8'h08;
                3: a = 8'hFF;
                default: a = 8'($urandom);
            endcase
            if (a == 8'h80) a = 8'h81;
            d = $urandom;
            if ($urandom_range(0, 1) == 1) begin
                ser_write(a, d);
                if (a == 8'h00) mode_m = d;
                if (a == 8'h02) mux_m = d;
                chk("R2 random mode_o", mode_w, mode_m);
                chk("R3 random mux_o", mux_w, mux_m);
            end else begin
                ser_read(a, rd);
                chk(req_of(a), rd, exp_rd(a));
            end
        end

        sw = $urandom;
        ser_read(8'h08, rd); chk("R4 new switch", rd, sw);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule